// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer

This block is a register-mapped timer peripheral. A single 16-bit prescaler divides the system clock into a tick, and a parameterised set of one to eight 32-bit channels count down on that tick. Each channel has its own reload register, its own control word and its own interrupt line. A channel expires when its count passes below zero, not when it reaches zero. On expiry it either reloads and keeps running or stops.

Software programs the block through a plain word-addressed port. A write is a single cycle with `bus_we` high. Read data is registered and appears in the cycle after the address is presented.

A read-only status word describes the block: its channel count, its interrupt numbering base, and two fixed capability flags. Interrupt pending flags are sticky and are cleared by writing a one to them.

Top module: `tick_timer_bank`

## Requirements
- R1: After a synchronous reset, all of the following hold: every counter, reload and control register reads 0, the prescaler registers read 0, and every interrupt line is low.
- R2: The status word at byte offset 0x08 reads {22'b0, 1, 1, IRQ_BASE[4:0], NCH mod 8}. With the defaults (NCH=2, IRQ_BASE=8) it reads 0x342. Writes to it have no effect.
- R3: The prescaler value (0x00) and the prescaler reload (0x04) keep only the low 16 bits of a write. The prescaler emits one tick every (reload+1) clocks.
- R4: Channel n uses the window at 0x10*(n+1): counter at +0x0, reload at +0x4, control at +0x8. A channel started at count N expires on the (N+1)-th tick. Without auto-reload it then stops: control bit0 (enable) reads 0 and the counter reads 0xFFFFFFFF.
- R5: On expiry with control bit3 (interrupt enable) set, the channel raises its interrupt line for exactly one clock and sets control bit4 (pending). With bit3 clear, neither the line nor bit4 changes.
- R6: Pending is sticky. Writing control with bit4=1 clears it. Writing control with bit4=0 leaves it as it was.
- R7: Writing control with bit2 (load) set copies the reload register into the counter. Counting starts if bit0 is set in the same write. Bit2 always reads 0.
- R8: With control bit1 (auto-reload) set, an expiry reloads the counter from the reload register and counting continues. Successive expiries are then (reload+1) ticks apart.
- R9: A write to the counter sets the count. A disabled channel holds that count, and enabling it without load counts down from it.
- R10: Reads of offsets that map to no register, including the windows of channels beyond NCH, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | NCH | One-clock expiry pulse per channel |

## Verification
The checker assumes the address on `bus_addr` is stable for the cycle it is read. It also assumes reset is held for at least one edge, so that the registered read path has been loaded before any read result is judged.

The bench writes only aligned addresses. It measures expiry intervals only while the prescaler is in steady state, and disables every channel before it changes the prescaler reload. This keeps each measured interval free of a partial prescaler period.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int DATA_W = 32;

  // unit-level byte offsets
  localparam logic [7:0] OFS_PS_VAL = 8'h00;
  localparam logic [7:0] OFS_PS_RLD = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h08;

  // offsets inside a 16-byte channel window
  localparam logic [3:0] OFS_CNT = 4'h0;
  localparam logic [3:0] OFS_RLD = 4'h4;
  localparam logic [3:0] OFS_CTL = 4'h8;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_AUTO = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_IE   = 3;
  localparam int CB_PEND = 4;

  function automatic logic [DATA_W-1:0] status_word(input int nch, input int irq_base);
    logic [DATA_W-1:0] w;
    w = '0;
    w[2:0] = 3'(nch % 8);
    w[7:3] = 5'(irq_base % 32);
    w[8]   = 1'b1;
    w[9]   = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            val_we,
  input  logic            rld_we,
  input  logic [PS_W-1:0] wdata,
  output logic [PS_W-1:0] val_o,
  output logic [PS_W-1:0] rld_o,
  output logic            tick_o
);
  logic [PS_W-1:0] val_q, rld_q;
  logic            tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      rld_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (rld_we) rld_q <= wdata;
      if (val_we) begin
        val_q  <= wdata;
        tick_q <= 1'b0;
      end else if (val_q == '0) begin
        val_q  <= rld_q;
        tick_q <= 1'b1;
      end else begin
        val_q  <= val_q - 1'b1;
        tick_q <= 1'b0;
      end
    end
  end

  assign val_o  = val_q;
  assign rld_o  = rld_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
  import ttb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_we,
  input  logic              rld_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             en_q, auto_q, ie_q, pend_q, irq_q;
  logic             expire;
  logic             pend_clr;

  assign expire   = tick && en_q && (cnt_q == '0);
  assign pend_clr = ctl_we && wdata[CB_PEND];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire && ie_q;
      // an expiry in the same cycle as a clearing write keeps the flag set
      pend_q <= (pend_q && !pend_clr) || (expire && ie_q);
      if (rld_we) rld_q <= wdata[CNT_W-1:0];
      if (ctl_we) begin
        en_q   <= wdata[CB_EN];
        auto_q <= wdata[CB_AUTO];
        ie_q   <= wdata[CB_IE];
        if (wdata[CB_LOAD]) cnt_q <= rld_q;
      end else if (cnt_we) begin
        cnt_q <= wdata[CNT_W-1:0];
      end else if (expire) begin
        if (auto_q) begin
          cnt_q <= rld_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          en_q  <= 1'b0;
        end
      end else if (tick && en_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o[CB_EN]   = en_q;
    ctl_o[CB_AUTO] = auto_q;
    ctl_o[CB_IE]   = ie_q;
    ctl_o[CB_PEND] = pend_q;
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ttb_readmux.sv
module ttb_readmux
  import ttb_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CNT_W    = 32,
  parameter int PS_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int IRQ_BASE = 8
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PS_W-1:0]             ps_val,
  input  logic [PS_W-1:0]             ps_rld,
  input  logic [NCH-1:0][CNT_W-1:0]   ch_cnt,
  input  logic [NCH-1:0][CNT_W-1:0]   ch_rld,
  input  logic [NCH-1:0][DATA_W-1:0]  ch_ctl,
  output logic [DATA_W-1:0]           data
);
  localparam int WIN_W = ADDR_W - 4;
  localparam logic [DATA_W-1:0] STATUS = status_word(NCH, IRQ_BASE);

  always_comb begin
    data = '0;
    if (addr == ADDR_W'(OFS_PS_VAL)) data = DATA_W'(ps_val);
    if (addr == ADDR_W'(OFS_PS_RLD)) data = DATA_W'(ps_rld);
    if (addr == ADDR_W'(OFS_STATUS)) data = STATUS;
    for (int n = 0; n < NCH; n++) begin
      if (addr[ADDR_W-1:4] == WIN_W'(n + 1)) begin
        case (addr[3:0])
          OFS_CNT: data = DATA_W'(ch_cnt[n]);
          OFS_RLD: data = DATA_W'(ch_rld[n]);
          OFS_CTL: data = ch_ctl[n];
          default: data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import ttb_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CNT_W    = 32,
  parameter int PS_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int IRQ_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int WIN_W = ADDR_W - 4;

  initial begin
    if (NCH < 1 || NCH > 8) $error("NCH must be 1..8");
    if (ADDR_W < 8) $error("ADDR_W must be at least 8");
  end

  logic [PS_W-1:0]             ps_val, ps_rld;
  logic                        ps_tick;
  logic [NCH-1:0][CNT_W-1:0]   ch_cnt, ch_rld;
  logic [NCH-1:0][DATA_W-1:0]  ch_ctl;
  logic [NCH-1:0]              pend_vec;
  logic [DATA_W-1:0]           rd_next;
  logic [DATA_W-1:0]           rdata_q;

  ttb_prescaler #(.PS_W(PS_W)) u_ps (
    .clk    (clk),
    .rst    (rst),
    .val_we (bus_we && bus_addr == ADDR_W'(OFS_PS_VAL)),
    .rld_we (bus_we && bus_addr == ADDR_W'(OFS_PS_RLD)),
    .wdata  (bus_wdata[PS_W-1:0]),
    .val_o  (ps_val),
    .rld_o  (ps_rld),
    .tick_o (ps_tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = bus_we && (bus_addr[ADDR_W-1:4] == WIN_W'(n + 1));
    ttb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .tick   (ps_tick),
      .cnt_we (hit && bus_addr[3:0] == OFS_CNT),
      .rld_we (hit && bus_addr[3:0] == OFS_RLD),
      .ctl_we (hit && bus_addr[3:0] == OFS_CTL),
      .wdata  (bus_wdata),
      .cnt_o  (ch_cnt[n]),
      .rld_o  (ch_rld[n]),
      .ctl_o  (ch_ctl[n]),
      .pend_o (pend_vec[n]),
      .irq_o  (irq[n])
    );
  end

  ttb_readmux #(
    .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .IRQ_BASE(IRQ_BASE)
  ) u_rd (
    .addr   (bus_addr),
    .ps_val (ps_val),
    .ps_rld (ps_rld),
    .ch_cnt (ch_cnt),
    .ch_rld (ch_rld),
    .ch_ctl (ch_ctl),
    .data   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker
  import ttb_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 8,
  parameter int IRQ_BASE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    pend,
  input logic              tick
);
  localparam logic [31:0] STATUS = status_word(NCH, IRQ_BASE);
  logic rd_ok;

  always_ff @(posedge clk) begin
    if (rst) rd_ok <= 1'b0;
    else     rd_ok <= 1'b1;
  end

  AST_STATUS_WORD: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && $past(bus_addr) == ADDR_W'(OFS_STATUS)) |-> bus_rdata == STATUS); // R2

  AST_PS_RLD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && $past(bus_addr) == ADDR_W'(OFS_PS_RLD)) |-> bus_rdata[31:16] == 16'h0); // R3

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && $past(bus_addr) == ADDR_W'(8'h0C)) |-> bus_rdata == 32'h0); // R10

  for (genvar n = 0; n < NCH; n++) begin : g_irq
    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      (rd_ok && irq[n]) |-> $past(tick)); // R4

    AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
      irq[n] |-> pend[n]); // R5

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (rd_ok && $past(pend[n]) && !pend[n]) |-> !irq[n]); // R6
  end
endmodule

bind tick_timer_bank ttb_checker #(
  .NCH(NCH), .ADDR_W(ADDR_W), .IRQ_BASE(IRQ_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .pend      (pend_vec),
  .tick      (ps_tick)
);

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_bank #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h0C; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'h0C;
  endtask

  // cycles after the current negedge until irq[ch] is seen high
  task automatic wait_irq(int ch, int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (irq[ch]) begin n = k; return; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h08, d); check("R1/R2 status after reset", d, 32'h342);
    rd(8'h10, d); check("R1 counter0 reset", d, 0);
    rd(8'h28, d); check("R1 control1 reset", d, 0);
    rd(8'h04, d); check("R1 prescaler reload reset", d, 0);
    check("R1 irq low", 32'(irq), 0);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R2 status ignores write", d, 32'h342);
  endtask

  task automatic t_ps_mask();
    logic [31:0] d;
    wr(8'h04, 32'hABCD_0003);
    rd(8'h04, d); check("R3 reload upper bits dropped", d, 32'h3);
    wr(8'h04, 32'h0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_oneshot();
    logic [31:0] d; int n;
    wr(8'h14, 32'd5);
    wr(8'h18, 32'h0D);
    wait_irq(0, 40, n); check("R4 start 5 expires after 6 ticks", n, 6);
    @(negedge clk); check("R5 irq one clock wide", 32'(irq[0]), 0);
    rd(8'h18, d); check("R4/R5/R7 control: stopped, pending, load reads 0", d, 32'h18);
    rd(8'h10, d); check("R4 counter after stop", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr(8'h18, 32'h08);
    rd(8'h18, d); check("R6 bit4=0 keeps pending", d, 32'h18);
    wr(8'h18, 32'h18);
    rd(8'h18, d); check("R6 bit4=1 clears pending", d, 32'h08);
  endtask

  task automatic t_no_ie();
    logic [31:0] d; int n;
    wr(8'h14, 32'd3);
    wr(8'h18, 32'h05);
    wait_irq(0, 12, n); check("R5 no irq without enable", n, 0);
    rd(8'h18, d); check("R5 no pending without enable", d, 32'h0);
    rd(8'h10, d); check("R4 stopped counter", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_cnt_write();
    logic [31:0] d; int n;
    wr(8'h10, 32'd4);
    repeat (3) @(negedge clk);
    rd(8'h10, d); check("R9 disabled channel holds written count", d, 32'd4);
    wr(8'h18, 32'h09);
    wait_irq(0, 30, n); check("R9 count from written value", n, 5);
    wr(8'h18, 32'h10);
  endtask

  task automatic t_restart();
    logic [31:0] d; int n;
    wr(8'h24, 32'd2);
    wr(8'h28, 32'h0F);
    wait_irq(1, 20, n); check("R7/R4 load then first expiry", n, 3);
    wait_irq(1, 20, n); check("R8 auto-reload interval", n, 3);
    wait_irq(1, 20, n); check("R8 auto-reload interval again", n, 3);
    rd(8'h28, d); check("R8 still enabled with pending", d, 32'h1B);
    wr(8'h28, 32'h10);
    repeat (4) @(negedge clk);
    rd(8'h28, d); check("R6 stop and clear", d, 32'h0);
  endtask

  task automatic t_prescale();
    int n;
    wr(8'h04, 32'd3);
    wr(8'h24, 32'd0);
    wr(8'h28, 32'h0F);
    wait_irq(1, 40, n);
    wait_irq(1, 40, n); check("R3 tick every reload+1 clocks", n, 4);
    wait_irq(1, 40, n); check("R3 tick period steady", n, 4);
    wr(8'h28, 32'h10);
    wr(8'h04, 32'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h0C, d); check("R10 hole in unit window", d, 0);
    rd(8'h30, d); check("R10 channel beyond NCH", d, 0);
    rd(8'h1C, d); check("R10 hole in channel window", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status_ro();
    t_ps_mask();
    t_oneshot();
    t_pending();
    t_no_ie();
    t_cnt_write();
    t_restart();
    t_prescale();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule